// File: doc/BRIEF.md
# Stage-based compressor array multiplier

This block is the unsigned significand multiplier of a small posit multiplier. A partial-product generator forms every AND term of the two N-bit operands. The terms are then reduced one column at a time by 2N-1 column stages. Stage k handles result column k and emits result bit k.

Each stage uses only 4:2 compressors and full adders. The carries that a stage produces enter the next stage, so the whole network carries from the least significant column to the most significant one. Within one column there is no ripple, because the carry-out of a 4:2 compressor does not depend on its carry-in. Widening the operands only changes how many cells each stage holds.

A parameter can place a single register cut after any stage except the last. This gives one cycle of latency and full throughput. The cut is meant to sit at the midpoint of the complete fraction path, which includes downstream rounding, so the default cut sits later than the multiplier's own centre. Rounding, normalisation and sign and exception handling live outside this block.

Top module: `cmp_array_mul`

## Requirements
- R1: With `PIPE_AFTER` = -1 the block is purely combinational. In every state, `prod_o` equals the unsigned product `a_i * b_i` zero-extended to 2N+1 bits, for all 2^(2N) operand pairs.
- R2: With `PIPE_AFTER` in 0..2N-3, `prod_o` equals the product of the operands presented one clock edge earlier. New operands are accepted on every cycle.
- R3: `valid_o` follows `valid_i` with the same latency as the data: zero cycles when combinational, one cycle when a cut is present. Data is computed whatever `valid_i` is.
- R4: In the pipelined build, while `rst_ni` is low, `valid_o` reads 0 and `prod_o` reads 0, whatever the inputs are.
- R5: The result bus is 2N+1 bits wide. Bit 2N is always 0, and no result ever exceeds (2^N-1)^2.
- R6: With both operands at their maximum, 2^N-1, the result is (2^N-1)^2, which needs the carry chain across every column. For N=5 this is 961 (0x3C1).
- R7: If either operand is 0 the result is 0. If one operand is 1 the result equals the other operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional pipeline cut |
| rst_ni | input | 1 | Active-low asynchronous reset of the cut registers |
| valid_i | input | 1 | Qualifier travelling with the operands |
| a_i | input | N | Unsigned multiplicand |
| b_i | input | N | Unsigned multiplier |
| valid_o | output | 1 | `valid_i` delayed by the block latency |
| prod_o | output | 2N+1 | Product; bit k comes from column stage k, bit 2N-1 from the final carries |

## Verification
Every operand pair is covered for both the combinational build and the build cut after stage N, so the cut must carry every column link. If a cut dropped a cell's carry-out or carry-in, some high bits would be wrong for a subset of pairs. All-ones operands drive the longest carry chain. A stage that lost its tail full-adder carry would return a value below 961 there. Zero and unit operands show stray carry injection as a nonzero or shifted result. Checks made during reset and a random valid pattern expose a valid signal that is not delayed together with the data.

// File: rtl/mul_pkg.sv
package mul_pkg;
  // 4:2 compressors chained in each column; one full adder closes the column
  function automatic int cmp_per_col(input int n);
    return (n - 1) / 2;
  endfunction

  // link bits between adjacent stages: plain carries, compressor carry-outs, tail carry
  function automatic int link_width(input int n);
    return 2 * ((n - 1) / 2) + 1;
  endfunction

  // new-bit slots a column can absorb
  function automatic int slot_width(input int n);
    return 3 * ((n - 1) / 2) + 3;
  endfunction
endpackage

// File: rtl/fa_cell.sv
module fa_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic co_o
);
  assign s_o  = a_i ^ b_i ^ c_i;
  assign co_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
endmodule

// File: rtl/comp42_cell.sv
module comp42_cell (
  input  logic x1_i,
  input  logic x2_i,
  input  logic x3_i,
  input  logic x4_i,
  input  logic cin_i,
  output logic s_o,
  output logic c_o,
  output logic cout_o
);
  logic mid;

  // cout_o depends only on x1..x3, so no ripple within a column
  fa_cell u_upper (
    .a_i (x1_i),
    .b_i (x2_i),
    .c_i (x3_i),
    .s_o (mid),
    .co_o(cout_o)
  );

  fa_cell u_lower (
    .a_i (mid),
    .b_i (x4_i),
    .c_i (cin_i),
    .s_o (s_o),
    .co_o(c_o)
  );
endmodule

// File: rtl/pp_gen.sv
module pp_gen #(
  parameter int N = 5
) (
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  output logic [N*N-1:0] pp_o
);
  // pp_o[i*N+j] = a_i[i] & b_i[j], weight i+j
  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      assign pp_o[i*N+j] = a_i[i] & b_i[j];
    end
  end
endmodule

// File: rtl/col_stage.sv
module col_stage #(
  parameter int N = 5
) (
  input  logic [N-1:0]                     col_i,
  input  logic [mul_pkg::link_width(N)-1:0] link_i,
  output logic                             sum_o,
  output logic [mul_pkg::link_width(N)-1:0] link_o
);
  localparam int J   = mul_pkg::cmp_per_col(N);
  localparam int LW  = mul_pkg::link_width(N);
  localparam int NBW = mul_pkg::slot_width(N);
  localparam int USED = N + J + 1;

  // link layout: [J-1:0] plain carries, [2J-1:J] compressor carry-outs, [2J] tail carry
  logic [NBW-1:0] nb;
  logic [J-1:0]   s_w, c_w, co_w;
  logic           tail_co;

  assign nb = NBW'({link_i[2*J], link_i[J-1:0], col_i});

  for (genvar j = 0; j < J; j++) begin : g_cmp
    if (j == 0) begin : g_head
      comp42_cell u_cmp (
        .x1_i  (nb[0]),
        .x2_i  (nb[1]),
        .x3_i  (nb[2]),
        .x4_i  (nb[3]),
        .cin_i (link_i[J+j]),
        .s_o   (s_w[j]),
        .c_o   (c_w[j]),
        .cout_o(co_w[j])
      );
    end else begin : g_body
      comp42_cell u_cmp (
        .x1_i  (s_w[j-1]),
        .x2_i  (nb[3*j+1]),
        .x3_i  (nb[3*j+2]),
        .x4_i  (nb[3*j+3]),
        .cin_i (link_i[J+j]),
        .s_o   (s_w[j]),
        .c_o   (c_w[j]),
        .cout_o(co_w[j])
      );
    end
  end

  fa_cell u_tail (
    .a_i (s_w[J-1]),
    .b_i (nb[3*J+1]),
    .c_i (nb[3*J+2]),
    .s_o (sum_o),
    .co_o(tail_co)
  );

  assign link_o = {tail_co, co_w, c_w};

  if (USED > NBW) begin : g_cap_err
    $error("col_stage: column capacity too small");
  end
  if (LW != 2*J+1) begin : g_lw_err
    $error("col_stage: link width mismatch");
  end
endmodule

// File: rtl/cmp_array_mul.sv
module cmp_array_mul #(
  parameter int N          = 5,
  parameter int PIPE_AFTER = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  output logic           valid_o,
  output logic [2*N:0]   prod_o
);
  localparam int  NS    = 2*N - 1;
  localparam int  LW    = mul_pkg::link_width(N);
  localparam bit  PIPED = (PIPE_AFTER >= 0);

  logic [N*N-1:0] pp_d;
  logic [LW-1:0]  link_out [NS];
  logic [NS-1:0]  sum_w;

  pp_gen #(.N(N)) u_ppg (
    .a_i (a_i),
    .b_i (b_i),
    .pp_o(pp_d)
  );

  for (genvar k = 0; k < NS; k++) begin : g_stage
    logic [N-1:0]  col_d, col_use;
    logic [LW-1:0] lin;
    logic          sum_d;

    // column k: terms a[i]&b[k-i]
    for (genvar i = 0; i < N; i++) begin : g_gather
      if ((k - i) >= 0 && (k - i) < N) begin : g_hit
        assign col_d[i] = pp_d[i*N + (k-i)];
      end else begin : g_pad
        assign col_d[i] = 1'b0;
      end
    end

    if (PIPED && k > PIPE_AFTER) begin : g_col_reg
      logic [N-1:0] col_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) col_q <= '0;
        else         col_q <= col_d;
      end
      assign col_use = col_q;
    end else begin : g_col_thru
      assign col_use = col_d;
    end

    if (k == 0) begin : g_first
      assign lin = '0;
    end else if (PIPED && k == PIPE_AFTER + 1) begin : g_link_reg
      logic [LW-1:0] link_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) link_q <= '0;
        else         link_q <= link_out[k-1];
      end
      assign lin = link_q;
    end else begin : g_link_thru
      assign lin = link_out[k-1];
    end

    col_stage #(.N(N)) u_col (
      .col_i (col_use),
      .link_i(lin),
      .sum_o (sum_d),
      .link_o(link_out[k])
    );

    if (PIPED && k <= PIPE_AFTER) begin : g_sum_reg
      logic sum_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sum_q <= 1'b0;
        else         sum_q <= sum_d;
      end
      assign sum_w[k] = sum_q;
    end else begin : g_sum_thru
      assign sum_w[k] = sum_d;
    end
  end

  if (PIPED) begin : g_vld_reg
    logic valid_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) valid_q <= 1'b0;
      else         valid_q <= valid_i;
    end
    assign valid_o = valid_q;
  end else begin : g_vld_thru
    assign valid_o = valid_i;
  end

  // leftover carries of the last column hold at most one set bit
  assign prod_o = {1'b0, ^link_out[NS-1], sum_w};

  if (N < 3 || PIPE_AFTER < -1 || PIPE_AFTER > NS - 2) begin : g_param_err
    $error("cmp_array_mul: unsupported N or PIPE_AFTER");
  end
endmodule

// File: rtl/cmp_array_mul_chk.sv
module cmp_array_mul_chk #(
  parameter int N          = 5,
  parameter int PIPE_AFTER = 5
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [N-1:0] a_i,
  input logic [N-1:0] b_i,
  input logic         valid_o,
  input logic [2*N:0] prod_o
);
  localparam int PW = 2*N + 1;
  localparam logic [PW-1:0] MAXV = PW'((2**N - 1) * (2**N - 1));

  // R5
  a_r5_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prod_o <= MAXV);

  if (PIPE_AFTER < 0) begin : g_comb
    a_r1_product: assert property (@(posedge clk_i) disable iff (!rst_ni)
      prod_o == PW'(a_i) * PW'(b_i));
    a_r3_valid_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o == valid_i);
    a_r7_zero_operand: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_i == '0 || b_i == '0) |-> prod_o == '0);
  end else begin : g_pipe
    logic primed;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) primed <= 1'b0;
      else         primed <= 1'b1;
    end
    a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      primed |-> prod_o == PW'($past(a_i)) * PW'($past(b_i)));
    a_r3_valid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
      primed |-> valid_o == $past(valid_i));
    always @(posedge clk_i) begin
      if (!rst_ni) begin
        a_r4_reset_clear: assert (valid_o == 1'b0 && prod_o == '0);
      end
    end
  end
endmodule

bind cmp_array_mul cmp_array_mul_chk #(.N(N), .PIPE_AFTER(PIPE_AFTER)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .a_i    (a_i),
  .b_i    (b_i),
  .valid_o(valid_o),
  .prod_o (prod_o)
);

// File: tb/cmp_array_mul_test.sv
module cmp_array_mul_test;
  localparam int N  = 5;
  localparam int PW = 2*N + 1;

  logic clk, rst_n, vld;
  logic [N-1:0] a, b;
  logic          vo_p, vo_c;
  logic [PW-1:0] pr_p, pr_c;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  cmp_array_mul #(.N(N), .PIPE_AFTER(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .a_i(a), .b_i(b),
    .valid_o(vo_p), .prod_o(pr_p)
  );

  cmp_array_mul #(.N(N), .PIPE_AFTER(-1)) uut_comb (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .a_i(a), .b_i(b),
    .valid_o(vo_c), .prod_o(pr_c)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [PW-1:0] ref_mul(input logic [N-1:0] x, input logic [N-1:0] y);
    logic [PW-1:0] acc = '0;
    for (int i = 0; i < N; i++)
      if (y[i]) acc = acc + (PW'(x) << i);
    return acc;
  endfunction

  task automatic chk(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive after a falling edge; combinational instance checked 1 ns later,
  // pipelined instance at the next falling edge
  task automatic step(input string tag, input logic [N-1:0] x, input logic [N-1:0] y, input logic v);
    a = x; b = y; vld = v;
    #1;
    chk(tag, pr_c, ref_mul(x, y));
    chk("R3", PW'(vo_c), PW'(v));
    @(negedge clk);
    chk("R2", pr_p, ref_mul(x, y));
    chk("R3", PW'(vo_p), PW'(v));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b1; vld = 1'b1; a = '1; b = 5'd9;
    #2 rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    // R4: cut registers stay clear while reset is held
    chk("R4", pr_p, '0);
    chk("R4", PW'(vo_p), '0);
    rst_n = 1'b1;

    // R6: all ones, full carry chain
    step("R6", '1, '1, 1'b1);
    chk("R6", pr_p, PW'(961));
    // R5: top bit is zero
    chk("R5", PW'(pr_p[2*N]), '0);

    // R7: zero and unit operands
    step("R7", 5'd0, 5'd31, 1'b1);
    step("R7", 5'd19, 5'd0, 1'b0);
    step("R7", 5'd1, 5'd23, 1'b1);
    step("R7", 5'd14, 5'd1, 1'b0);

    // R1: every operand pair, back to back
    for (int i = 0; i < (1 << N); i++)
      for (int j = 0; j < (1 << N); j++)
        step("R1", N'(i), N'(j), 1'b1);

    // R1/R3: random operands with random valid
    for (int r = 0; r < 3000; r++)
      step("R1", N'($urandom), N'($urandom), 1'($urandom));

    chk("R5", PW'(pr_c[2*N]), '0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule